// File: doc/BRIEF.md
# Serial Status Readout Port

This block lets a host controller read a frequency synthesizer's status over a four-wire serial link. Three lines come from the host: a chip-enable, a serial clock and a data-in line. The fourth line, data-out, returns bits to the host. The block samples all host lines with its own system clock through a synchronizer chain and acts on the edges it detects.

While chip-enable is low, the host shifts in an address byte on rising serial-clock edges. When chip-enable then rises and the byte just received equals the read address, the port enters read mode. In that same system-clock cycle it freezes a status snapshot. The snapshot holds the levels of two I/O pins, a lock flag and a 20-bit frequency-count value.

The snapshot goes out most significant bit first. The first bit is on data-out as soon as read mode begins, and each falling serial-clock edge brings the next bit. The data-out driver is modelled as an output-enable. That enable is high only in read mode, so the line is released whenever chip-enable is low.

Top module: `status_readout`

## Requirements
- R1: After reset, `ser_dout_oe` and `ser_dout` are both low.
- R2: While `ser_ce` is low, each rising `ser_clk` edge shifts `ser_din` into an 8-bit address, first bit received ending as bit 7. A rising `ser_ce` enters read mode (`ser_dout_oe` high) only when that byte equals `READ_ADDR` (default 0xA5). Each rising `ser_ce` consumes the address.
- R3: If the address does not match, `ser_dout_oe` and `ser_dout` stay low through the whole high period of `ser_ce`, even while `ser_clk` toggles.
- R4: `ser_dout_oe` is high throughout read mode and goes low after `ser_ce` falls. `ser_dout` is low whenever `ser_dout_oe` is low.
- R5: The frame is 23 bits, sent in this order: `io_pin[1]`, `io_pin[0]`, the lock bit, then `if_count[19]` down to `if_count[0]`. The first bit is present when read mode begins, and each falling `ser_clk` edge advances the frame by one bit.
- R6: The lock bit is 1 when `pll_locked` is high or `unlock_det_en` is low. It is 0 only when detection is enabled and the loop is unlocked.
- R7: The pin bits, lock bit and count are captured in the cycle read mode begins. Changes on those inputs during the shift do not alter the frame.
- R8: After all 23 bits have been shifted out, `ser_dout` is low for any further falling `ser_clk` edges until `ser_ce` falls.
- R9: A fall of `ser_ce` in mid-frame aborts the transfer. A later `ser_ce` high period with no new matching address leaves the port idle. The next valid read returns a fresh snapshot.
- R10: A rising `ser_clk` edge in read mode does not change `ser_dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the host lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_ce | input | 1 | Host chip-enable |
| ser_clk | input | 1 | Host serial clock |
| ser_din | input | 1 | Host serial data in (address byte) |
| io_pin | input | 2 | Levels of the two I/O pins |
| pll_locked | input | 1 | Lock indication from the unlock detector |
| unlock_det_en | input | 1 | High when unlock detection is active |
| if_count | input | 20 | Frequency-count value |
| ser_dout | output | 1 | Serial status data out |
| ser_dout_oe | output | 1 | Data-out driver enable |

## Verification
The bench uses the default build: a 20-bit count, the 8-bit address 0xA5 and two synchronizer stages. It reads every combination of the two pin levels, the lock flag and the detection enable. Each combination is read against an all-zero, an all-one and a mixed count, and a walking one covers every count bit. This reaches every frame position and every way the lock bit can form. Separate passes cover a wrong address, inputs changing during a shift, extra clocks after the last bit, and an aborted frame followed by a high period with no address.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  localparam int unsigned DEF_CNT_W  = 20;
  localparam int unsigned DEF_ADDR_W = 8;

  // Header bits that lead the frame, most significant first
  typedef struct packed {
    logic io_hi;
    logic io_lo;
    logic lock_ok;
  } status_hdr_t;

  localparam int unsigned HDR_W = $bits(status_hdr_t);

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [W-1:0] r;
    logic [W-1:0] r_d;
    if (s == 0) begin : g_in
      assign r_d = d;
    end else begin : g_chain
      assign r_d = g_stg[s-1].r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else        r <= r_d;
    end
  end

  assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/addr_match.sv
module addr_match #(
  parameter int unsigned           ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]     READ_ADDR = 8'hA5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_lvl,
  input  logic din_lvl,
  input  logic sclk_rise,
  input  logic ce_rise,
  output logic rd_hit
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = 1'b0;
    addr_d  = addr_q;
    if (ce_rise) begin
      addr_en = 1'b1;
      addr_d  = '0;
    end else if (sclk_rise && !ce_lvl) begin
      addr_en = 1'b1;
      addr_d  = {addr_q[ADDR_W-2:0], din_lvl};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign rd_hit = ce_rise && (addr_q == READ_ADDR);

  // R2: the address is consumed by every chip-enable rise
  assert_addr_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise |=> (addr_q == '0));

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned FRAME_W = 23
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               shift_en,
  input  logic               abort,
  output logic               active,
  output logic               dout
);

  localparam int unsigned CNT_B = $clog2(FRAME_W + 1);

  logic               active_q, active_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [CNT_B-1:0]   cnt_q, cnt_d;
  logic               upd;

  always_comb begin
    upd      = 1'b0;
    active_d = active_q;
    frame_d  = frame_q;
    cnt_d    = cnt_q;
    if (abort) begin
      upd      = 1'b1;
      active_d = 1'b0;
      frame_d  = '0;
      cnt_d    = '0;
    end else if (load) begin
      upd      = 1'b1;
      active_d = 1'b1;
      frame_d  = frame_in;
      cnt_d    = '0;
    end else if (active_q && shift_en) begin
      upd     = 1'b1;
      frame_d = {frame_q[FRAME_W-2:0], 1'b0};
      if (cnt_q != CNT_B'(FRAME_W)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      frame_q  <= '0;
      cnt_q    <= '0;
    end else if (upd) begin
      active_q <= active_d;
      frame_q  <= frame_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active = active_q;
  assign dout   = active_q & frame_q[FRAME_W-1];

  // R8: the shift count never passes the frame length
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_B'(FRAME_W));

  // R8: once the whole frame has gone out only zeros remain
  assert_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q == CNT_B'(FRAME_W)) |-> (frame_q == '0));

  // R7, R10: the held frame moves only on a falling serial clock or a new load
  assert_hold_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !shift_en && !load && !abort) |=> $stable(frame_q));

endmodule

// File: rtl/status_readout.sv
module status_readout
  import tsr_pkg::*;
#(
  parameter int unsigned       CNT_W       = DEF_CNT_W,
  parameter int unsigned       ADDR_W      = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] READ_ADDR   = 8'hA5,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_ce,
  input  logic             ser_clk,
  input  logic             ser_din,
  input  logic [1:0]       io_pin,
  input  logic             pll_locked,
  input  logic             unlock_det_en,
  input  logic [CNT_W-1:0] if_count,
  output logic             ser_dout,
  output logic             ser_dout_oe
);

  localparam int unsigned FRAME_W = CNT_W + HDR_W;

  logic [2:0]         lvl;
  logic               ce_s, sclk_s, din_s;
  logic               ce_prev, sclk_prev;
  logic               ce_rise, ce_fall, sclk_rise, sclk_fall;
  logic               rd_hit, active;
  status_hdr_t        hdr;
  logic [FRAME_W-1:0] frame_in;

  line_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_ce, ser_clk, ser_din}),
    .q     (lvl)
  );

  assign {ce_s, sclk_s, din_s} = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev   <= 1'b0;
      sclk_prev <= 1'b0;
    end else begin
      ce_prev   <= ce_s;
      sclk_prev <= sclk_s;
    end
  end

  assign ce_rise   =  ce_s   & ~ce_prev;
  assign ce_fall   = ~ce_s   &  ce_prev;
  assign sclk_rise =  sclk_s & ~sclk_prev;
  assign sclk_fall = ~sclk_s &  sclk_prev;

  addr_match #(.ADDR_W(ADDR_W), .READ_ADDR(READ_ADDR)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_lvl    (ce_s),
    .din_lvl   (din_s),
    .sclk_rise (sclk_rise),
    .ce_rise   (ce_rise),
    .rd_hit    (rd_hit)
  );

  // Pin bits report the pin level; lock merges locked and detection off
  always_comb begin
    hdr.io_hi   = io_pin[1];
    hdr.io_lo   = io_pin[0];
    hdr.lock_ok = pll_locked | ~unlock_det_en;
  end

  assign frame_in = {hdr, if_count};

  frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rd_hit),
    .frame_in (frame_in),
    .shift_en (sclk_fall & ce_s),
    .abort    (ce_fall),
    .active   (active),
    .dout     (ser_dout)
  );

  assign ser_dout_oe = active;

  // R4: the driver is released once chip-enable has been low two cycles
  assert_oe_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_s && $past(!ce_s)) |-> !ser_dout_oe);

  // R4: data-out is quiet when not driven
  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_dout_oe |-> !ser_dout);

  // R2: read mode starts only right after a chip-enable rise
  assert_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_dout_oe) |-> $past(ce_rise));

endmodule

// File: tb/tb_status_readout.sv
module tb_status_readout;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int FW         = 23;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_ce, ser_clk, ser_din;
  logic [1:0]  io_pin;
  logic        pll_locked, unlock_det_en;
  logic [19:0] if_count;
  logic        ser_dout, ser_dout_oe;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_readout dut (
    .clk(clk), .rst_n(rst_n), .ser_ce(ser_ce), .ser_clk(ser_clk),
    .ser_din(ser_din), .io_pin(io_pin), .pll_locked(pll_locked),
    .unlock_det_en(unlock_det_en), .if_count(if_count),
    .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] expect_frame(input logic [1:0] io, input logic lk,
                                                 input logic en, input logic [19:0] c);
    return {io[1], io[0], (lk | ~en), c};
  endfunction

  task automatic send_addr(input logic [7:0] a);
    ser_ce = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      ser_din = a[i];
      wait_clk(HALF);
      ser_clk = 1'b1;
      wait_clk(HALF);
      ser_clk = 1'b0;
    end
    wait_clk(HALF);
  endtask

  task automatic read_frame(input logic [7:0] a, input int nbits, input bit chg,
                            output logic [FW-1:0] got);
    send_addr(a);
    ser_ce = 1'b1;
    wait_clk(HALF);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      got[FW-1-i] = ser_dout;
      check(ser_dout_oe == 1'b1, "R4 oe in read", 32'(ser_dout_oe), 1);
      ser_clk = 1'b1;
      wait_clk(HALF);
      check(ser_dout == got[FW-1-i], "R10 rising edge moved data", 32'(ser_dout),
            32'(got[FW-1-i]));
      if (chg && i == 0) begin
        io_pin     = ~io_pin;
        if_count   = ~if_count;
        pll_locked = ~pll_locked;
      end
      ser_clk = 1'b0;
      wait_clk(HALF);
    end
  endtask

  task automatic end_read();
    ser_ce = 1'b0;
    wait_clk(HALF);
    check(ser_dout_oe == 1'b0, "R4 oe after ce low", 32'(ser_dout_oe), 0);
    check(ser_dout == 1'b0, "R4 dout after ce low", 32'(ser_dout), 0);
  endtask

  task automatic full_check(input logic [19:0] c, input string tag);
    logic [FW-1:0] exp, got;
    if_count = c;
    exp = expect_frame(io_pin, pll_locked, unlock_det_en, c);
    read_frame(8'hA5, FW, 1'b0, got);
    check(got == exp, tag, 32'(got), 32'(exp));
    end_read();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [FW-1:0] got, exp;
    rst_n = 1'b0; ser_ce = 1'b0; ser_clk = 1'b0; ser_din = 1'b0;
    io_pin = 2'b00; pll_locked = 1'b0; unlock_det_en = 1'b1; if_count = '0;
    wait_clk(5);
    check(ser_dout_oe == 1'b0, "R1 oe at reset", 32'(ser_dout_oe), 0);
    check(ser_dout == 1'b0, "R1 dout at reset", 32'(ser_dout), 0);
    rst_n = 1'b1;
    wait_clk(4);
    check(ser_dout_oe == 1'b0 && ser_dout == 1'b0, "R1 idle after reset",
          32'({ser_dout_oe, ser_dout}), 0);

    // R5, R6, R2: sweep header combinations against three counts
    for (int io = 0; io < 4; io++)
      for (int lk = 0; lk < 2; lk++)
        for (int en = 0; en < 2; en++) begin
          io_pin = 2'(io); pll_locked = 1'(lk); unlock_det_en = 1'(en);
          full_check(20'h00000, "R6 frame zero count");
          full_check(20'hFFFFF, "R5 frame full count");
          full_check(20'((io * 37 + lk * 11 + en * 5) * 20'h2F3A5 + 20'h5C1), "R5 frame mixed");
        end

    // R5: walking one over each count bit
    io_pin = 2'b10; pll_locked = 1'b1; unlock_det_en = 1'b1;
    for (int b = 0; b < 20; b++) full_check(20'(1) << b, "R5 walking count bit");

    // R3: wrong addresses keep the port idle
    for (int k = 0; k < 4; k++) begin
      logic [7:0] bad;
      bad = 8'hA5 ^ (8'h01 << (k * 2));
      send_addr(bad);
      ser_ce = 1'b1;
      for (int i = 0; i < 4; i++) begin
        wait_clk(HALF);
        check(ser_dout_oe == 1'b0 && ser_dout == 1'b0, "R3 bad address idle",
              32'({ser_dout_oe, ser_dout}), 0);
        ser_clk = 1'b1; wait_clk(HALF); ser_clk = 1'b0;
      end
      ser_ce = 1'b0;
      wait_clk(HALF);
    end

    // R7: inputs flip after the shift starts
    io_pin = 2'b01; pll_locked = 1'b0; unlock_det_en = 1'b1; if_count = 20'hA3C5E;
    exp = expect_frame(io_pin, pll_locked, unlock_det_en, if_count);
    read_frame(8'hA5, FW, 1'b1, got);
    check(got == exp, "R7 snapshot frozen", 32'(got), 32'(exp));

    // R8: extra falling edges after the frame give zeros
    for (int i = 0; i < 3; i++) begin
      check(ser_dout == 1'b0 && ser_dout_oe == 1'b1, "R8 drained frame",
            32'({ser_dout_oe, ser_dout}), 32'(2'b10));
      ser_clk = 1'b1; wait_clk(HALF); ser_clk = 1'b0; wait_clk(HALF);
    end
    end_read();

    // R9: abort mid-frame, then a high period with no address
    io_pin = 2'b11; pll_locked = 1'b1; unlock_det_en = 1'b1; if_count = 20'h12345;
    exp = expect_frame(io_pin, pll_locked, unlock_det_en, if_count);
    read_frame(8'hA5, 5, 1'b0, got);
    check(got[FW-1:FW-5] == exp[FW-1:FW-5], "R9 partial frame", 32'(got[FW-1:FW-5]),
          32'(exp[FW-1:FW-5]));
    end_read();
    ser_ce = 1'b1;
    for (int i = 0; i < 3; i++) begin
      wait_clk(HALF);
      check(ser_dout_oe == 1'b0, "R9 no address no read", 32'(ser_dout_oe), 0);
      ser_clk = 1'b1; wait_clk(HALF); ser_clk = 1'b0;
    end
    ser_ce = 1'b0;
    wait_clk(HALF);
    io_pin = 2'b00; pll_locked = 1'b0; unlock_det_en = 1'b0;
    full_check(20'h0F0F1, "R9 fresh snapshot");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule